// File: doc/BRIEF.md
# Packed Decimal Byte Arithmetic Unit

This unit performs two-digit packed BCD addition, subtraction and negation on byte operands. An extend bit is folded in as carry-in or borrow-in. It produces a result byte and five condition flags: extend, negative, zero, overflow and carry. The unit is meant to sit behind the operand-fetch stage of a processor datapath. Its zero flag is built for multi-byte decimal chains. A chain of byte operations starts with zero set, and each byte can only clear it, so after the last byte the flag tells whether the whole multi-byte value is zero.

Every one of the 256 codes of each operand is accepted, including nibbles above 9. Each code gives a fixed, fully defined result and flag set. Subtraction and negation do not test the result for decimal validity the way addition does. They take their correction from the borrows of the binary subtraction. The arithmetic is combinational and feeds a single registered output stage with a valid strobe. The digit count is a parameter, and the ports below are shown for the default of two digits.

Top module: `bcd_unit`

## Requirements
- R1: While reset is asserted (rst_n low), and after reset is released until the first accepted operation, out_valid, result and all five flags are 0.
- R2: An operation presented with in_valid high appears at the outputs one clock later with out_valid high. A cycle with in_valid low drives out_valid low on the next clock and leaves result and all flags unchanged.
- R3: Add (op_sel 2'b00, and also the unused code 2'b11) forms the binary sum S = src + dst + x_in. It adds 6 to the low digit when the low-nibble sum carries out or its low nibble exceeds 9. It adds 0x60 when S exceeds 255 or its low byte is at least 0x9A. The result is the low byte of the corrected sum.
- R4: For add, c_out is 1 when the high digit was corrected or when adding the correction overflows the byte. x_out always equals c_out for every operation.
- R5: Subtract (op_sel 2'b01) forms the binary difference D = dst - src - x_in. It removes 6 when the low-nibble subtraction borrows, and removes 0x60 when the byte subtraction borrows. The result is the low byte of the corrected difference.
- R6: For subtract and negate, c_out is 1 when the binary byte subtraction borrows or when removing the correction borrows.
- R7: Negate (op_sel 2'b10) gives exactly the result and flags of subtract with dst taken as 0x00, whatever dst holds.
- R8: z_out is 1 only when z_in is 1 and the result byte is 0x00. A zero result never sets it.
- R9: n_out equals bit 7 of the result byte.
- R10: For add, v_out is 1 when bit 7 of the binary sum is 0 and bit 7 of the result is 1. For subtract and negate, v_out is 1 when bit 7 of the binary difference is 1 and bit 7 of the result is 0.
- R11: Subtracting 0x00 from 0x00 with x_in 1 gives 0x99 with X, N and C set and V clear, for either z_in. Subtracting 0x00 from 0x01, 0x02, 0x10 or 0x20 with x_in 1 gives 0x00, 0x01, 0x09 and 0x19 with X, N, V and C clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation present this cycle |
| op_sel | input | 2 | 00 add, 01 subtract, 10 negate, 11 add |
| src_byte | input | 8 | Source operand (subtrahend or addend) |
| dst_byte | input | 8 | Destination operand (minuend or addend) |
| x_in | input | 1 | Incoming extend bit (carry/borrow in) |
| z_in | input | 1 | Incoming zero flag |
| out_valid | output | 1 | Result registered this cycle |
| result | output | 8 | Corrected BCD result |
| x_out | output | 1 | Extend flag |
| n_out | output | 1 | Negative flag |
| z_out | output | 1 | Zero flag |
| v_out | output | 1 | Overflow flag |
| c_out | output | 1 | Carry/borrow flag |

## Verification
Add and subtract are swept over every source byte, against a stepped set of destination bytes, with all four extend/zero combinations. Negate is swept over its whole space of 1024 inputs. These sweeps cover both decimal codes and invalid nibbles. They separate the asymmetric correction rules, since a subtract that checked decimal validity would fail on inputs such as 0x10 - 0x00. Directed vectors pin the borrow-to-0x99 case and the sticky zero with z_in both set and clear. They also run negate with a nonzero dst, apply the unused opcode, and hold inputs idle while the operands change, which shows that the outputs keep their values.

// File: rtl/bcd_pkg.sv
package bcd_pkg;

    typedef enum logic [1:0] {
        OP_ADD = 2'b00,
        OP_SUB = 2'b01,
        OP_NEG = 2'b10,
        OP_ALT = 2'b11
    } bcd_op_e;

    // Correction value for one digit.
    localparam logic [3:0] DIGIT_FIX = 4'h6;

endpackage

// File: rtl/bcd_add_core.sv
module bcd_add_core #(
    parameter int NDIG = 2
) (
    input  logic [4*NDIG-1:0] a,
    input  logic [4*NDIG-1:0] b,
    input  logic              cin,
    output logic [4*NDIG-1:0] sum,
    output logic              carry,
    output logic              ovf
);
    localparam int W = 4 * NDIG;
    localparam logic [W-1:0] BIAS = {NDIG{bcd_pkg::DIGIT_FIX}};

    logic [W:0]   bin_sum;
    logic [W:0]   carry_in_bits;
    logic [W+1:0] biased;
    logic [W+1:0] over_nine;
    logic [NDIG-1:0] adj;
    logic [W:0]   corf;
    logic [W:0]   fixed;

    always_comb begin
        bin_sum       = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
        carry_in_bits = {1'b0, a} ^ {1'b0, b} ^ bin_sum;
        biased        = {1'b0, bin_sum} + {2'b00, BIAS};
        over_nine     = biased ^ {1'b0, bin_sum};
    end

    for (genvar i = 0; i < NDIG; i++) begin : g_dig
        assign adj[i] = carry_in_bits[4*i+4] | over_nine[4*i+4];
        assign corf[4*i+3:4*i] = adj[i] ? bcd_pkg::DIGIT_FIX : 4'h0;
    end
    assign corf[W] = 1'b0;

    always_comb begin
        fixed = {1'b0, bin_sum[W-1:0]} + corf;
        sum   = fixed[W-1:0];
        carry = adj[NDIG-1] | fixed[W];
        ovf   = ~bin_sum[W-1] & fixed[W-1];
    end

endmodule

// File: rtl/bcd_sub_core.sv
module bcd_sub_core #(
    parameter int NDIG = 2
) (
    input  logic [4*NDIG-1:0] minu,
    input  logic [4*NDIG-1:0] subt,
    input  logic              bin_in,
    output logic [4*NDIG-1:0] diff,
    output logic              borrow,
    output logic              ovf
);
    localparam int W = 4 * NDIG;

    logic [W:0]      bin_diff;
    logic [W:0]      borrow_bits;
    logic [NDIG-1:0] adj;
    logic [W:0]      corf;
    logic [W:0]      fixed;

    always_comb begin
        bin_diff    = {1'b0, minu} - {1'b0, subt} - {{W{1'b0}}, bin_in};
        borrow_bits = {1'b0, minu} ^ {1'b0, subt} ^ bin_diff;
    end

    for (genvar i = 0; i < NDIG; i++) begin : g_dig
        assign adj[i] = borrow_bits[4*i+4];
        assign corf[4*i+3:4*i] = adj[i] ? bcd_pkg::DIGIT_FIX : 4'h0;
    end
    assign corf[W] = 1'b0;

    always_comb begin
        fixed  = {1'b0, bin_diff[W-1:0]} - corf;
        diff   = fixed[W-1:0];
        borrow = bin_diff[W] | fixed[W];
        ovf    = bin_diff[W-1] & ~fixed[W-1];
    end

endmodule

// File: rtl/bcd_unit.sv
module bcd_unit #(
    parameter int NDIG = 2,
    parameter int W    = 4 * NDIG
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic [1:0]   op_sel,
    input  logic [W-1:0] src_byte,
    input  logic [W-1:0] dst_byte,
    input  logic         x_in,
    input  logic         z_in,
    output logic         out_valid,
    output logic [W-1:0] result,
    output logic         x_out,
    output logic         n_out,
    output logic         z_out,
    output logic         v_out,
    output logic         c_out
);
    import bcd_pkg::*;

    typedef struct packed {
        logic         vld;
        logic [W-1:0] res;
        logic         xf;
        logic         nf;
        logic         zf;
        logic         vf;
        logic         cf;
    } stage_t;

    stage_t st_d, st_q;
    bcd_op_e op;

    logic [W-1:0] add_res, sub_res, minu_d;
    logic         add_cy, add_v, sub_bo, sub_v;

    assign op     = bcd_op_e'(op_sel);
    assign minu_d = (op == OP_NEG) ? '0 : dst_byte;

    bcd_add_core #(.NDIG(NDIG)) u_add (
        .a(dst_byte), .b(src_byte), .cin(x_in),
        .sum(add_res), .carry(add_cy), .ovf(add_v)
    );

    bcd_sub_core #(.NDIG(NDIG)) u_sub (
        .minu(minu_d), .subt(src_byte), .bin_in(x_in),
        .diff(sub_res), .borrow(sub_bo), .ovf(sub_v)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_valid;
        if (in_valid) begin
            if (op == OP_SUB || op == OP_NEG) begin
                st_d.res = sub_res;
                st_d.cf  = sub_bo;
                st_d.vf  = sub_v;
            end else begin
                st_d.res = add_res;
                st_d.cf  = add_cy;
                st_d.vf  = add_v;
            end
            st_d.xf = st_d.cf;
            st_d.nf = st_d.res[W-1];
            st_d.zf = z_in & ~|st_d.res;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.vld;
    assign result    = st_q.res;
    assign x_out     = st_q.xf;
    assign n_out     = st_q.nf;
    assign z_out     = st_q.zf;
    assign v_out     = st_q.vf;
    assign c_out     = st_q.cf;

endmodule

// File: rtl/bcd_unit_chk.sv
module bcd_unit_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         in_valid,
    input logic         z_in,
    input logic         out_valid,
    input logic [W-1:0] result,
    input logic         x_out,
    input logic         n_out,
    input logic         z_out,
    input logic         c_out
);
    p_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    p_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(result) && $stable(z_out)));
    p_x_is_c_r4: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (x_out == c_out));
    p_sign_bit_r9: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (n_out == result[W-1]));
    p_zero_never_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !z_in) |=> !z_out);
    p_zero_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (z_out == ($past(z_in) && (result == '0))));
endmodule

bind bcd_unit bcd_unit_chk #(.W(W)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .z_in(z_in),
    .out_valid(out_valid), .result(result), .x_out(x_out),
    .n_out(n_out), .z_out(z_out), .c_out(c_out)
);

// File: tb/sim_bcd_unit.sv
module sim_bcd_unit;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [1:0] op_sel = 2'b00;
    logic [7:0] src_byte = '0, dst_byte = '0;
    logic       x_in = 1'b0, z_in = 1'b0;
    logic       out_valid;
    logic [7:0] result;
    logic       x_out, n_out, z_out, v_out, c_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    bcd_unit u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_sel(op_sel),
        .src_byte(src_byte), .dst_byte(dst_byte), .x_in(x_in), .z_in(z_in),
        .out_valid(out_valid), .result(result), .x_out(x_out), .n_out(n_out),
        .z_out(z_out), .v_out(v_out), .c_out(c_out)
    );

    // expected values of the pending operation
    bit   pend = 1'b0;
    int   e_res;
    bit   e_c, e_n, e_z, e_v;
    logic [1:0] e_op;

    task automatic model(input logic [1:0] op, input int s, input int d,
                         input bit x, input bit z);
        int raw, lo, cf, t, r8;
        bit lc, hc;
        if (op == 2'b01 || op == 2'b10) begin
            if (op == 2'b10) d = 0;
            raw = d - s - int'(x);
            lc  = (d % 16) < (s % 16) + int'(x);
            hc  = raw < 0;
            r8  = (raw + 256) % 256;
            cf  = (lc ? 6 : 0) + (hc ? 96 : 0);
            t   = r8 - cf;
            e_res = (t + 256) % 256;
            e_c = hc || (t < 0);
            e_v = (r8 >= 128) && (e_res < 128);
        end else begin
            raw = s + d + int'(x);
            lo  = (s % 16) + (d % 16) + int'(x);
            lc  = (lo > 15) || ((lo % 16) > 9);
            hc  = (raw > 255) || ((raw % 256) >= 154);
            cf  = (lc ? 6 : 0) + (hc ? 96 : 0);
            t   = (raw % 256) + cf;
            e_res = t % 256;
            e_c = hc || (t > 255);
            e_v = ((raw % 256) < 128) && (e_res >= 128);
        end
        e_n = e_res >= 128;
        e_z = z && (e_res == 0);
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // called at a negedge: check last op, then present the next one
    task automatic check_pending();
        if (pend) begin
            chk("R2 out_valid", int'(out_valid), 1);
            if (e_op == 2'b01)      chk("R5 result", int'(result), e_res);
            else if (e_op == 2'b10) chk("R7 result", int'(result), e_res);
            else                    chk("R3 result", int'(result), e_res);
            if (e_op == 2'b01 || e_op == 2'b10) chk("R6 c_out", int'(c_out), int'(e_c));
            else                                chk("R4 c_out", int'(c_out), int'(e_c));
            chk("R4 x_out", int'(x_out), int'(e_c));
            chk("R9 n_out", int'(n_out), int'(e_n));
            chk("R8 z_out", int'(z_out), int'(e_z));
            chk("R10 v_out", int'(v_out), int'(e_v));
        end
    endtask

    task automatic apply(input logic [1:0] op, input int s, input int d,
                         input bit x, input bit z);
        @(negedge clk);
        check_pending();
        op_sel = op; src_byte = 8'(s); dst_byte = 8'(d);
        x_in = x; z_in = z; in_valid = 1'b1;
        model(op, s, d, x, z);
        e_op = op;
        pend = 1'b1;
    endtask

    task automatic flush();
        @(negedge clk);
        check_pending();
        in_valid = 1'b0;
        pend = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 out_valid in reset", int'(out_valid), 0);
        chk("R1 result in reset", int'(result), 0);
        chk("R1 flags in reset", int'({x_out, n_out, z_out, v_out, c_out}), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1 out_valid after reset", int'(out_valid), 0);
        chk("R1 result after reset", int'(result), 0);

        // R11 directed subtract cases
        apply(2'b01, 8'h00, 8'h00, 1'b1, 1'b0);
        apply(2'b01, 8'h00, 8'h00, 1'b1, 1'b1);
        flush();
        apply(2'b01, 8'h00, 8'h00, 1'b1, 1'b1);
        @(negedge clk);
        chk("R11 0-0-1 result", int'(result), 8'h99);
        chk("R11 0-0-1 XNZVC", int'({x_out, n_out, z_out, v_out, c_out}), 5'b11001);
        in_valid = 1'b0; pend = 1'b0;
        apply(2'b01, 8'h00, 8'h01, 1'b1, 1'b1);
        @(negedge clk);
        chk("R11 1-0-1 result", int'(result), 8'h00);
        chk("R8 zero kept set", int'(z_out), 1);
        chk("R11 1-0-1 XNVC", int'({x_out, n_out, v_out, c_out}), 0);
        in_valid = 1'b0; pend = 1'b0;
        apply(2'b01, 8'h00, 8'h01, 1'b1, 1'b0);
        @(negedge clk);
        chk("R8 zero kept clear", int'(z_out), 0);
        in_valid = 1'b0; pend = 1'b0;
        apply(2'b01, 8'h00, 8'h02, 1'b1, 1'b0);
        @(negedge clk);
        chk("R11 2-0-1", int'({result, x_out, n_out, v_out, c_out}), {8'h01, 4'b0});
        in_valid = 1'b0; pend = 1'b0;
        apply(2'b01, 8'h00, 8'h10, 1'b1, 1'b0);
        @(negedge clk);
        chk("R11 10-0-1", int'({result, x_out, n_out, v_out, c_out}), {8'h09, 4'b0});
        in_valid = 1'b0; pend = 1'b0;
        apply(2'b01, 8'h00, 8'h20, 1'b1, 1'b0);
        @(negedge clk);
        chk("R11 20-0-1", int'(result), 8'h19);
        in_valid = 1'b0; pend = 1'b0;

        // R2 hold: idle cycles with changed operands leave outputs unchanged
        src_byte = 8'h55; dst_byte = 8'h44; x_in = 1'b0; z_in = 1'b1; op_sel = 2'b00;
        repeat (2) @(negedge clk);
        chk("R2 idle out_valid", int'(out_valid), 0);
        chk("R2 idle result held", int'(result), 8'h19);
        chk("R2 idle flags held", int'({x_out, n_out, z_out, v_out, c_out}), 0);

        // R7 negate ignores dst; R3 spare opcode behaves as add
        apply(2'b10, 8'h37, 8'hC4, 1'b0, 1'b1);
        apply(2'b10, 8'h00, 8'h99, 1'b0, 1'b1);
        apply(2'b11, 8'h45, 8'h38, 1'b1, 1'b0);
        apply(2'b00, 8'h99, 8'h01, 1'b0, 1'b1);
        flush();

        // add and subtract sweeps: all src, stepped dst, all x/z
        for (int op = 0; op < 2; op++)
            for (int s = 0; s < 256; s++)
                for (int d = s % 3; d < 256; d += 3)
                    for (int xz = 0; xz < 4; xz++)
                        if (((s + d + xz) % 4) == 0 || (d % 15) == 0)
                            apply(2'(op), s, d, xz[0], xz[1]);
        flush();

        // negate full sweep (R7)
        for (int s = 0; s < 256; s++)
            for (int xz = 0; xz < 4; xz++)
                apply(2'b10, s, (s * 7) % 256, xz[0], xz[1]);
        flush();

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R2 watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule